// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers reset requests from five on-chip sources and turns any of them into a timed reset sequence. Every phase is counted in cycles of the reference oscillator clock. While the sequence runs, the block pulls the shared active-low reset pad down through an open-drain enable, so that other devices on the board are reset too. It then keeps the internal reset asserted for a further period after it lets the pad go.

Power-on and low-voltage requests get a long extra phase of pad pull-down before the normal sequence. The watchdog request arrives asynchronously and passes through a synchronizer first. The block also watches the pad: when something outside pulls it low while the block is idle, it runs the standard sequence. A six-bit cause register records which sources requested a reset. Its pad bit is set only when the pad is still low at a fixed sampling point after the sequence. Software clears the register by reading it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A request from illegal-address, illegal-opcode, power-on or low-voltage that is high at a clock edge makes `pin_pd_o` and `irst_o` high from the next cycle on.
- R2: In a standard (non-power) sequence `pin_pd_o` is high for exactly 32 cycles, and `pin_pd_o` is never high while `irst_o` is low.
- R3: In a standard sequence `irst_o` stays high for 32 cycles after the pad is released, so it is high for 64 cycles in total.
- R4: A power-on or low-voltage request first holds the pad for an extra 4096 cycles, so `pin_pd_o` lasts 4128 cycles and `irst_o` lasts 4160 cycles.
- R5: The watchdog input passes through a two-flop synchronizer: when it goes high before clock edge 1, `pin_pd_o` is still low after edges 1 and 2 and goes high after edge 3.
- R6: Cause bit 5 (pad) is set only from the synchronized pad level sampled 3 cycles after `irst_o` falls, which is cycle 67 of a standard sequence and cycle 4163 of a power sequence. If the pad is high at that point the bit stays clear.
- R7: A request that arrives during a running sequence sets its cause bit and restarts the sequence from its first phase. A restart keeps the long phase when the running sequence was a power sequence.
- R8: Cause bits: bit0 power-on, bit1 low-voltage, bit2 watchdog, bit3 illegal opcode, bit4 illegal address, bit5 pad. A power-on request leaves only bit0 set.
- R9: `cause_rd_i` high at an edge clears `cause_o` for the next cycle, except for bits that are set by a request at that same edge.
- R10: If the synchronized pad level is low while the block is idle, the block runs the standard sequence. The pad is sampled through two flops, so `pin_pd_o` goes high after the third edge.
- R11: While `rst_ni` is low, `pin_pd_o`, `irst_o` and `cause_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_req_i | input | 1 | Power-on reset request |
| lvd_req_i | input | 1 | Low-voltage reset request |
| wdt_req_i | input | 1 | Watchdog timeout request, asynchronous |
| bad_addr_i | input | 1 | Illegal-address strobe |
| bad_op_i | input | 1 | Illegal-opcode strobe |
| pin_level_i | input | 1 | Sampled level of the external reset pad |
| cause_rd_i | input | 1 | Cause register read strobe (clears on read) |
| pin_pd_o | output | 1 | Open-drain pull-down enable for the reset pad |
| irst_o | output | 1 | Internal reset, active high |
| cause_o | output | 6 | Reset cause register |

## Verification
Two functions can act on the cause register in the same cycle: the clear triggered by a software read, and the setting of a bit by a new request. The bench raises `cause_rd_i` and the illegal-opcode strobe at the same edge. It then expects the old illegal-address bit to be gone and the opcode bit to be present in the next cycle. A second pair of events collides when a new request arrives mid-sequence while the pad phase is counting down. That case is judged by the total number of pull-down cycles and internal-reset cycles, each counted from the first request.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_STRETCH,
    SEQ_PIN_LOW,
    SEQ_IRST_HOLD,
    SEQ_DONE
  } seq_state_e;

  localparam int unsigned NUM_CAUSE   = 6;
  localparam int unsigned CAUSE_POR   = 0;
  localparam int unsigned CAUSE_LVD   = 1;
  localparam int unsigned CAUSE_WDT   = 2;
  localparam int unsigned CAUSE_OP    = 3;
  localparam int unsigned CAUSE_ADDR  = 4;
  localparam int unsigned CAUSE_PIN   = 5;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 4096,
  parameter int unsigned PIN_CYC     = 32,
  parameter int unsigned HOLD_CYC    = 32,
  parameter int unsigned SAMPLE_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pwr_i,
  input  logic ext_low_i,
  output logic pin_pd_o,
  output logic irst_o,
  output logic sample_o
);

  localparam int unsigned MAX_CYC = max2(max2(STRETCH_CYC, PIN_CYC), max2(HOLD_CYC, SAMPLE_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STRETCH_LD = CNT_W'(STRETCH_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_LD     = CNT_W'(PIN_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LD  = CNT_W'(SAMPLE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwr_q, pwr_d;
  logic             live;
  logic             cnt_zero;

  assign live     = (state_q == SEQ_STRETCH) || (state_q == SEQ_PIN_LOW) ||
                    (state_q == SEQ_IRST_HOLD);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pwr_d    = pwr_q;
    sample_o = 1'b0;
    if (req_i) begin
      // restart from first phase; power type survives a restart
      pwr_d = pwr_i | (live & pwr_q);
      if (pwr_d) begin
        state_d = SEQ_STRETCH;
        cnt_d   = STRETCH_LD;
      end else begin
        state_d = SEQ_PIN_LOW;
        cnt_d   = PIN_LD;
      end
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (ext_low_i) begin
            state_d = SEQ_PIN_LOW;
            cnt_d   = PIN_LD;
            pwr_d   = 1'b0;
          end
        end
        SEQ_STRETCH: begin
          if (cnt_zero) begin
            state_d = SEQ_PIN_LOW;
            cnt_d   = PIN_LD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SEQ_PIN_LOW: begin
          if (cnt_zero) begin
            state_d = SEQ_IRST_HOLD;
            cnt_d   = HOLD_LD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SEQ_IRST_HOLD: begin
          if (cnt_zero) begin
            state_d = SEQ_DONE;
            cnt_d   = SAMPLE_LD;
            pwr_d   = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        SEQ_DONE: begin
          if (cnt_zero) begin
            state_d  = SEQ_IDLE;
            sample_o = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
          pwr_d   = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pwr_q   <= pwr_d;
    end
  end

  assign pin_pd_o = (state_q == SEQ_STRETCH) || (state_q == SEQ_PIN_LOW);
  assign irst_o   = live;

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CAUSE-1:0] set_i,
  input  logic                 rd_i,
  output logic [NUM_CAUSE-1:0] cause_o
);

  logic [NUM_CAUSE-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = (rd_i ? '0 : cause_q) | set_i;
    if (set_i[CAUSE_POR]) begin
      cause_d = '0;
      cause_d[CAUSE_POR] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 4096,
  parameter int unsigned PIN_CYC     = 32,
  parameter int unsigned HOLD_CYC    = 32,
  parameter int unsigned SAMPLE_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_req_i,
  input  logic       lvd_req_i,
  input  logic       wdt_req_i,
  input  logic       bad_addr_i,
  input  logic       bad_op_i,
  input  logic       pin_level_i,
  input  logic       cause_rd_i,
  output logic       pin_pd_o,
  output logic       irst_o,
  output logic [5:0] cause_o
);

  logic                 wdt_s;
  logic                 pin_s;
  logic                 any_req;
  logic                 pwr_req;
  logic                 sample;
  logic [NUM_CAUSE-1:0] set_vec;

  rst_sync2 #(.W(1), .RST_VAL(1'b0)) i_wdt_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdt_req_i),
    .q_o   (wdt_s)
  );

  // pad idles high through its pull-up
  rst_sync2 #(.W(1), .RST_VAL(1'b1)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_level_i),
    .q_o   (pin_s)
  );

  assign pwr_req = por_req_i | lvd_req_i;
  assign any_req = pwr_req | wdt_s | bad_addr_i | bad_op_i;

  rst_seq_fsm #(
    .STRETCH_CYC(STRETCH_CYC),
    .PIN_CYC    (PIN_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .SAMPLE_CYC (SAMPLE_CYC)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (any_req),
    .pwr_i    (pwr_req),
    .ext_low_i(~pin_s),
    .pin_pd_o (pin_pd_o),
    .irst_o   (irst_o),
    .sample_o (sample)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[CAUSE_POR]  = por_req_i;
    set_vec[CAUSE_LVD]  = lvd_req_i;
    set_vec[CAUSE_WDT]  = wdt_s;
    set_vec[CAUSE_OP]   = bad_op_i;
    set_vec[CAUSE_ADDR] = bad_addr_i;
    set_vec[CAUSE_PIN]  = sample & ~pin_s;
  end

  rst_cause_reg i_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .rd_i   (cause_rd_i),
    .cause_o(cause_o)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned STRETCH_CYC = 4096,
  parameter int unsigned PIN_CYC     = 32,
  parameter int unsigned HOLD_CYC    = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_req_i,
  input logic       bad_addr_i,
  input logic       bad_op_i,
  input logic       cause_rd_i,
  input logic       pin_pd_o,
  input logic       irst_o,
  input logic [5:0] cause_o,
  input logic       any_req,
  input logic       pwr_req,
  input logic [5:0] set_vec,
  input logic       sample
);

  localparam int unsigned STD_LEN = PIN_CYC + HOLD_CYC;
  localparam int unsigned PWR_LEN = STD_LEN + STRETCH_CYC;

  logic [15:0] len_q;
  logic        pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      pwr_q <= 1'b0;
    end else begin
      len_q <= (any_req || !irst_o) ? '0 : len_q + 1'b1;
      if (any_req)      pwr_q <= pwr_req | (irst_o & pwr_q);
      else if (!irst_o) pwr_q <= 1'b0;
    end
  end

  // R1
  strobe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_addr_i || bad_op_i) |=> (pin_pd_o && irst_o));

  // R2
  pd_in_irst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pd_o |-> irst_o);

  // R3 R4
  irst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irst_o) |-> (len_q == (pwr_q ? 16'(PWR_LEN) : 16'(STD_LEN))));

  // R6
  pin_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o[5]) |-> $past(sample));

  // R8
  por_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |=> (cause_o == 6'b000001));

  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_rd_i && (set_vec == '0)) |=> (cause_o == '0));

endmodule

bind rst_seq_ctrl rst_seq_chk #(
  .STRETCH_CYC(STRETCH_CYC),
  .PIN_CYC    (PIN_CYC),
  .HOLD_CYC   (HOLD_CYC)
) i_rst_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_req_i (por_req_i),
  .bad_addr_i(bad_addr_i),
  .bad_op_i  (bad_op_i),
  .cause_rd_i(cause_rd_i),
  .pin_pd_o  (pin_pd_o),
  .irst_o    (irst_o),
  .cause_o   (cause_o),
  .any_req   (any_req),
  .pwr_req   (pwr_req),
  .set_vec   (set_vec),
  .sample    (sample)
);

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_req = 1'b0, lvd_req = 1'b0, wdt_req = 1'b0;
  logic       bad_addr = 1'b0, bad_op = 1'b0, cause_rd = 1'b0;
  logic       ext_low = 1'b0;
  logic       pin_lvl;
  logic       pin_pd, irst;
  logic [5:0] cause;

  int checks = 0;
  int errors = 0;
  int pd_cnt = 0;
  int irst_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // open-drain pad with pull-up
  assign pin_lvl = ~(pin_pd | ext_low);

  rst_seq_ctrl i_rst_seq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .por_req_i  (por_req),
    .lvd_req_i  (lvd_req),
    .wdt_req_i  (wdt_req),
    .bad_addr_i (bad_addr),
    .bad_op_i   (bad_op),
    .pin_level_i(pin_lvl),
    .cause_rd_i (cause_rd),
    .pin_pd_o   (pin_pd),
    .irst_o     (irst),
    .cause_o    (cause)
  );

  always @(posedge clk) begin
    if (pin_pd) pd_cnt++;
    if (irst)   irst_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_cnt();
    pd_cnt = 0;
    irst_cnt = 0;
  endtask

  task automatic wait_idle();
    while (irst) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic do_read();
    cause_rd = 1'b1;
    @(negedge clk);
    cause_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pin_pd in reset", int'(pin_pd), 0);
    chk("R11 irst in reset", int'(irst), 0);
    chk("R11 cause in reset", int'(cause), 0);
  endtask

  task automatic t_addr();
    clr_cnt();
    bad_addr = 1'b1;
    @(negedge clk);
    bad_addr = 1'b0;
    chk("R1 pin_pd after strobe", int'(pin_pd), 1);
    chk("R1 irst after strobe", int'(irst), 1);
    wait_idle();
    chk("R2 pad low cycles", pd_cnt, 32);
    chk("R3 irst cycles", irst_cnt, 64);
    chk("R8 addr cause bit4", int'(cause), 6'b010000);
    chk("R6 pad bit clear when pad high", int'(cause[5]), 0);
  endtask

  task automatic t_read_clear();
    // R9: read and new set in the same cycle
    cause_rd = 1'b1;
    bad_op = 1'b1;
    @(negedge clk);
    cause_rd = 1'b0;
    bad_op = 1'b0;
    chk("R9 read plus set same cycle", int'(cause), 6'b001000);
    wait_idle();
    do_read();
    chk("R9 read clears", int'(cause), 0);
  endtask

  task automatic t_wdt();
    clr_cnt();
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    chk("R5 no pd after edge1", int'(pin_pd), 0);
    @(negedge clk);
    chk("R5 no pd after edge2", int'(pin_pd), 0);
    @(negedge clk);
    chk("R5 pd after edge3", int'(pin_pd), 1);
    wait_idle();
    chk("R5 wdt pad cycles", pd_cnt, 32);
    chk("R8 wdt cause bit2", int'(cause), 6'b000100);
    do_read();
  endtask

  task automatic t_restart();
    clr_cnt();
    bad_addr = 1'b1;
    @(negedge clk);
    bad_addr = 1'b0;
    repeat (9) @(negedge clk);
    bad_op = 1'b1;
    @(negedge clk);
    bad_op = 1'b0;
    wait_idle();
    chk("R7 restart pad cycles", pd_cnt, 42);
    chk("R7 restart irst cycles", irst_cnt, 74);
    chk("R7 both causes kept", int'(cause), 6'b011000);
    do_read();
  endtask

  task automatic t_pin_cause();
    clr_cnt();
    bad_addr = 1'b1;
    @(negedge clk);
    bad_addr = 1'b0;
    repeat (50) @(negedge clk);
    ext_low = 1'b1;
    repeat (16) @(negedge clk);
    chk("R6 pad bit not before sample", int'(cause[5]), 0);
    @(negedge clk);
    chk("R6 pad bit at sample", int'(cause[5]), 1);
    repeat (4) @(negedge clk);
    ext_low = 1'b0;
    wait_idle();
    do_read();
    chk("R6 read clears pad bit", int'(cause), 0);
  endtask

  task automatic t_ext();
    clr_cnt();
    ext_low = 1'b1;
    @(negedge clk);
    chk("R10 no pd after edge1", int'(pin_pd), 0);
    @(negedge clk);
    chk("R10 no pd after edge2", int'(pin_pd), 0);
    @(negedge clk);
    chk("R10 pd after edge3", int'(pin_pd), 1);
    repeat (5) @(negedge clk);
    ext_low = 1'b0;
    wait_idle();
    chk("R10 ext pad cycles", pd_cnt, 32);
    chk("R10 ext irst cycles", irst_cnt, 64);
    chk("R6 released pad leaves bit clear", int'(cause), 0);
  endtask

  task automatic t_power();
    clr_cnt();
    lvd_req = 1'b1;
    @(negedge clk);
    lvd_req = 1'b0;
    wait_idle();
    chk("R4 power pad cycles", pd_cnt, 4128);
    chk("R4 power irst cycles", irst_cnt, 4160);
    chk("R8 lvd cause bit1", int'(cause), 6'b000010);
    bad_addr = 1'b1;
    @(negedge clk);
    bad_addr = 1'b0;
    wait_idle();
    clr_cnt();
    por_req = 1'b1;
    @(negedge clk);
    por_req = 1'b0;
    chk("R8 por leaves only bit0", int'(cause), 6'b000001);
    repeat (100) @(negedge clk);
    bad_op = 1'b1;
    @(negedge clk);
    bad_op = 1'b0;
    wait_idle();
    chk("R7 power restart pad cycles", pd_cnt, 101 + 4128);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_addr();
    t_read_clear();
    t_wdt();
    t_restart();
    t_pin_cause();
    t_ext();
    t_power();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule